// File: doc/BRIEF.md
# Serial Audio Link Start-Up and Codec Ready Detector

This block brings a serial audio codec link out of cold reset and reports when each attached codec is ready. A control bit, written by software, drives the active-low link reset pin. While that bit is clear the link is held in reset, and the block keeps its frame logic idle.

Once the bit is set, the block waits for the primary codec to start the bit clock. It watches the bit clock from the system clock domain through a synchronizer and counts toggles. After enough closely spaced toggles it considers the link running. From then on it generates the frame marker (SYNC) and tracks the bit position within the frame. The first bit of the tag slot on each serial data input is that codec's ready flag, sampled on a falling bit-clock edge. When the flag is seen as 1, the block sets a sticky status bit for that input. If software has enabled that bit, the interrupt output rises.

Software then learns that a codec is ready either by polling the status register or by taking the interrupt. Register writes use a simple write strobe with an address and data. Reads are combinational from a separate read address.

Top module: `aclk_link_start`

## Requirements
- R1: After system reset, `link_rst_no` is 0, `sync_o` is 0, `irq_o` is 0, and all three registers read as 0.
- R2: The control register is at address 0, with the link enable in bit 0. Writing 1 there drives `link_rst_no` high from the next cycle. Writing 0 drives it low from the next cycle.
- R3: While the link enable is 0, or while the bit clock has not yet shown 4 synchronized toggles each spaced fewer than 64 system cycles apart, `sync_o` stays 0. A gap of 64 cycles without a toggle restarts the toggle count.
- R4: Once the link counts as running, each synchronized bit-clock rising edge advances a frame position of 256 bits. The first rising edge starts position 0. `sync_o` is high while the position is below 16, so it is high for 16 of every 256 bit periods.
- R5: At the synchronized falling bit-clock edge in frame position 0, a 1 on `sdin_i[i]` sets status bit i. Lane 0 sets bit 0 and lane 1 sets bit 1. Each lane is independent of the other.
- R6: A 1 on `sdin_i` at any other falling edge, in any other frame position, or before framing has started, sets no status bit.
- R7: The status register is at address 1, with bit i for lane i. Its bits stay set until software writes 1 to that bit position. Writing 0 leaves a bit unchanged.
- R8: The interrupt enable register is at address 2, with bit i for lane i. `irq_o` is 1 exactly when some status bit and its enable bit are both 1.
- R9: Clearing the link enable stops `sync_o` from the second cycle after the write, clears framing, and re-arms clock detection. Status bits are kept. After the enable is set again, framing restarts only after a new detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low system reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Register read data, combinational |
| link_rst_no | output | 1 | Active-low link reset to the codecs |
| bitclk_i | input | 1 | Bit clock from the primary codec, asynchronous |
| sdin_i | input | 2 | Serial data inputs, one per codec |
| sync_o | output | 1 | Frame marker to the codecs |
| irq_o | output | 1 | Codec-ready interrupt |

## Verification
A register write becomes visible one cycle later on `link_rst_no` and on the read data. A bit-clock pin change reaches the detector two system cycles after it is driven. `sync_o` changes one cycle after the detector sees a rising edge, and a status bit, with `irq_o`, rises one cycle after the detector sees the falling edge at frame position 0. The bench advances a behavioural model by one system cycle for each clock, using the same two-cycle input delay. It compares every output at the falling system edge, after the design's registers have settled. It also makes explicit checks that measure SYNC width and frame period in system cycles, at a fixed eight-cycle bit period.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    localparam int unsigned ADDR_W = 2;

    typedef logic [ADDR_W-1:0] reg_addr_t;

    // Register map: link enable, sticky ready status, interrupt enable
    localparam reg_addr_t A_CTRL = 2'd0;
    localparam reg_addr_t A_STAT = 2'd1;
    localparam reg_addr_t A_IEN  = 2'd2;

endpackage

// File: rtl/aclk_sync.sv
module aclk_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign q_o = st_q.s2;

endmodule

// File: rtl/aclk_clkdet.sv
module aclk_clkdet #(
    parameter int unsigned MIN_TOGGLES = 4,
    parameter int unsigned DET_TIMEOUT = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic link_en_i,
    input  logic bclk_i,
    output logic rise_o,
    output logic fall_o,
    output logic run_o
);

    localparam int unsigned TW = $clog2(MIN_TOGGLES + 1);
    localparam int unsigned MW = $clog2(DET_TIMEOUT + 1);

    typedef struct packed {
        logic          prev;
        logic [TW-1:0] tog;
        logic [MW-1:0] tmo;
        logic          run;
    } det_t;

    det_t st_d, st_q;
    logic edge_seen;

    assign rise_o    = bclk_i & ~st_q.prev;
    assign fall_o    = ~bclk_i & st_q.prev;
    assign edge_seen = rise_o | fall_o;

    always_comb begin
        st_d      = st_q;
        st_d.prev = bclk_i;
        if (!link_en_i) begin
            st_d.tog = '0;
            st_d.tmo = '0;
            st_d.run = 1'b0;
        end else if (!st_q.run) begin
            if (edge_seen) begin
                st_d.tog = st_q.tog + 1'b1;
                st_d.tmo = '0;
                if (st_d.tog == TW'(MIN_TOGGLES)) st_d.run = 1'b1;
            end else begin
                st_d.tmo = st_q.tmo + 1'b1;
                if (st_d.tmo >= MW'(DET_TIMEOUT)) begin
                    st_d.tog = '0;
                    st_d.tmo = '0;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign run_o = st_q.run;

    // R3: once running, the link stays running until its enable drops
    p_run_kept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.run && link_en_i) |=> st_q.run);

endmodule

// File: rtl/aclk_framer.sv
module aclk_framer #(
    parameter int unsigned FRAME_BITS = 256,
    parameter int unsigned TAG_BITS   = 16,
    parameter int unsigned NLANE      = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             link_en_i,
    input  logic             run_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic [NLANE-1:0] sd_i,
    output logic             sync_o,
    output logic [NLANE-1:0] ready_set_o
);

    localparam int unsigned PW = $clog2(FRAME_BITS);

    typedef struct packed {
        logic          started;
        logic [PW-1:0] pos;
        logic          sync;
    } frm_t;

    frm_t st_d, st_q;
    logic at_ready_bit;

    always_comb begin
        st_d = st_q;
        if (!link_en_i || !run_i) begin
            st_d = '0;
        end else if (rise_i) begin
            if (!st_q.started) begin
                st_d.started = 1'b1;
                st_d.pos     = '0;
            end else if (st_q.pos == PW'(FRAME_BITS - 1)) begin
                st_d.pos = '0;
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
        st_d.sync = st_d.started && (st_d.pos < PW'(TAG_BITS));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sync_o       = st_q.sync;
    assign at_ready_bit = link_en_i && st_q.started && fall_i && (st_q.pos == '0);

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign ready_set_o[g] = at_ready_bit & sd_i[g];
    end

    // R9: a disabled link drops SYNC on the following cycle
    p_sync_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !link_en_i |=> !sync_o);

    // R3: SYNC only starts after the clock detector reported a running link
    p_sync_after_run_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sync_o) |-> $past(run_i));

endmodule

// File: rtl/aclk_regs.sv
module aclk_regs
    import aclk_pkg::*;
#(
    parameter int unsigned NLANE = 2,
    parameter int unsigned REG_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  reg_addr_t        wr_addr_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  reg_addr_t        rd_addr_i,
    output logic [REG_W-1:0] rd_data_o,
    input  logic [NLANE-1:0] ready_set_i,
    output logic             link_en_o,
    output logic             irq_o
);

    typedef struct packed {
        logic             en;
        logic [NLANE-1:0] stat;
        logic [NLANE-1:0] ien;
    } regs_t;

    regs_t st_d, st_q;
    logic [NLANE-1:0] clr;
    logic unused_wr_hi;

    assign unused_wr_hi = ^wr_data_i[REG_W-1:NLANE];

    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (wr_en_i) begin
            unique case (wr_addr_i)
                A_CTRL:  st_d.en  = wr_data_i[0];
                A_STAT:  clr      = wr_data_i[NLANE-1:0];
                A_IEN:   st_d.ien = wr_data_i[NLANE-1:0];
                default: ;
            endcase
        end
        st_d.stat = (st_q.stat & ~clr) | ready_set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        rd_data_o = '0;
        unique case (rd_addr_i)
            A_CTRL:  rd_data_o[0]         = st_q.en;
            A_STAT:  rd_data_o[NLANE-1:0] = st_q.stat;
            A_IEN:   rd_data_o[NLANE-1:0] = st_q.ien;
            default: ;
        endcase
    end

    assign link_en_o = st_q.en;
    assign irq_o     = |(st_q.stat & st_q.ien);

    // R7: a status bit only falls after a write of 1 to its position
    for (genvar g = 0; g < NLANE; g++) begin : g_chk
        p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(st_q.stat[g]) |-> $past(wr_en_i && wr_addr_i == A_STAT && wr_data_i[g]));
    end

endmodule

// File: rtl/aclk_link_start.sv
module aclk_link_start
    import aclk_pkg::*;
#(
    parameter int unsigned FRAME_BITS  = 256,
    parameter int unsigned TAG_BITS    = 16,
    parameter int unsigned MIN_TOGGLES = 4,
    parameter int unsigned DET_TIMEOUT = 64,
    parameter int unsigned NLANE       = 2,
    parameter int unsigned REG_W       = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic [1:0]       rd_addr_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             link_rst_no,
    input  logic             bitclk_i,
    input  logic [NLANE-1:0] sdin_i,
    output logic             sync_o,
    output logic             irq_o
);

    logic             link_en;
    logic             bclk_s;
    logic [NLANE-1:0] sd_s;
    logic             rise, fall, run;
    logic [NLANE-1:0] ready_set;

    aclk_sync #(.W(1)) u_bclk_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (bitclk_i),
        .q_o   (bclk_s)
    );

    aclk_sync #(.W(NLANE)) u_sd_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (sdin_i),
        .q_o   (sd_s)
    );

    aclk_clkdet #(
        .MIN_TOGGLES(MIN_TOGGLES),
        .DET_TIMEOUT(DET_TIMEOUT)
    ) u_det (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .link_en_i(link_en),
        .bclk_i   (bclk_s),
        .rise_o   (rise),
        .fall_o   (fall),
        .run_o    (run)
    );

    aclk_framer #(
        .FRAME_BITS(FRAME_BITS),
        .TAG_BITS  (TAG_BITS),
        .NLANE     (NLANE)
    ) u_frm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .link_en_i  (link_en),
        .run_i      (run),
        .rise_i     (rise),
        .fall_i     (fall),
        .sd_i       (sd_s),
        .sync_o     (sync_o),
        .ready_set_o(ready_set)
    );

    aclk_regs #(
        .NLANE(NLANE),
        .REG_W(REG_W)
    ) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .rd_addr_i  (rd_addr_i),
        .rd_data_o  (rd_data_o),
        .ready_set_i(ready_set),
        .link_en_o  (link_en),
        .irq_o      (irq_o)
    );

    assign link_rst_no = link_en;

    // R2: the link leaves reset only after software wrote a 1 to the enable
    p_release_by_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(link_rst_no) |-> $past(wr_en_i && wr_addr_i == A_CTRL && wr_data_i[0]));

endmodule

// File: tb/sim_aclk_link_start.sv
module sim_aclk_link_start;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       link_rst_n;
    logic       bitclk = 1'b0;
    logic [1:0] sdin = '0;
    logic       sync;
    logic       irq;

    always #4 clk = ~clk;

    aclk_link_start u0 (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .link_rst_no(link_rst_n),
        .bitclk_i   (bitclk),
        .sdin_i     (sdin),
        .sync_o     (sync),
        .irq_o      (irq)
    );

    int checks = 0;
    int errors = 0;

    // stimulus intent
    bit       b_we = 0;
    bit [1:0] b_wa = 0;
    bit [7:0] b_wd = 0;
    bit [1:0] b_ra = 0;
    bit       b_bc = 0;
    int       bc_half = 0;
    int       bc_cnt = 0;
    int       sd_mode [2] = '{0, 0};
    bit [1:0] cur_ra = 0;

    // behavioural reference
    bit       m_en = 0, m_run = 0, m_started = 0, m_sync = 0;
    bit [1:0] m_stat = 0, m_ien = 0;
    int       m_tog = 0, m_tmo = 0, m_pos = 0;
    bit       h_bc [$] = '{0, 0, 0};
    bit [1:0] h_sd [$] = '{2'b00, 2'b00, 2'b00};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit [7:0] exp_rd(input bit [1:0] a);
        case (a)
            2'd0:    return {7'b0, m_en};
            2'd1:    return {6'b0, m_stat};
            2'd2:    return {6'b0, m_ien};
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_step();
        bit lvl, prv, rise, fall;
        bit [1:0] sdv, setv, clr;
        bit n_en, n_run, n_started;
        bit [1:0] n_ien;
        int n_tog, n_tmo, n_pos;
        h_bc.push_front(b_bc);
        h_sd.push_front(sdin);
        while (h_bc.size() > 4) void'(h_bc.pop_back());
        while (h_sd.size() > 4) void'(h_sd.pop_back());
        lvl = h_bc[2]; prv = h_bc[3]; sdv = h_sd[2];
        rise = lvl && !prv;
        fall = !lvl && prv;
        setv = (m_en && m_started && fall && m_pos == 0) ? sdv : 2'b00;
        n_en = m_en; n_ien = m_ien; clr = 0;
        if (b_we) begin
            if (b_wa == 0) n_en = b_wd[0];
            else if (b_wa == 1) clr = b_wd[1:0];
            else if (b_wa == 2) n_ien = b_wd[1:0];
        end
        n_tog = m_tog; n_tmo = m_tmo; n_run = m_run;
        if (!m_en) begin
            n_tog = 0; n_tmo = 0; n_run = 0;
        end else if (!m_run) begin
            if (rise || fall) begin
                n_tog = m_tog + 1; n_tmo = 0;
                if (n_tog == 4) n_run = 1;
            end else begin
                n_tmo = m_tmo + 1;
                if (n_tmo >= 64) begin n_tog = 0; n_tmo = 0; end
            end
        end
        n_started = m_started; n_pos = m_pos;
        if (!m_en || !m_run) begin
            n_started = 0; n_pos = 0;
        end else if (rise) begin
            if (!m_started) begin n_started = 1; n_pos = 0; end
            else n_pos = (m_pos + 1) % 256;
        end
        m_stat    = (m_stat & ~clr) | setv;
        m_en      = n_en; m_ien = n_ien;
        m_tog     = n_tog; m_tmo = n_tmo; m_run = n_run;
        m_started = n_started; m_pos = n_pos;
        m_sync    = n_started && n_pos < 16;
    endtask

    task automatic cyc();
        bit [1:0] sv;
        @(negedge clk);
        chk(link_rst_n === m_en, "R2 link reset", link_rst_n, m_en);
        chk(sync === m_sync, "R4 sync", sync, m_sync);
        chk(irq === |(m_stat & m_ien), "R8 irq", irq, |(m_stat & m_ien));
        chk(rd_data === exp_rd(cur_ra), (cur_ra == 1) ? "R7 status read" : "R2 register read",
            rd_data, exp_rd(cur_ra));
        if (bc_half > 0) begin
            bc_cnt++;
            if (bc_cnt >= bc_half) begin bc_cnt = 0; b_bc = ~b_bc; end
        end
        for (int i = 0; i < 2; i++) begin
            case (sd_mode[i])
                1:       sv[i] = m_started && m_pos == 0;
                2:       sv[i] = m_started && m_pos >= 1 && m_pos < 16;
                3:       sv[i] = 1'b1;
                default: sv[i] = 1'b0;
            endcase
        end
        wr_en = b_we; wr_addr = b_wa; wr_data = b_wd; rd_addr = b_ra;
        bitclk = b_bc; sdin = sv; cur_ra = b_ra;
        model_step();
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input bit [1:0] a, input bit [7:0] d);
        b_we = 1; b_wa = a; b_wd = d;
        cyc();
        b_we = 0; b_wd = 0;
    endtask

    task automatic rd(input bit [1:0] a, output bit [7:0] d);
        b_ra = a;
        cyc();
        cyc();
        d = rd_data;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        finish_run();
    end

    initial begin
        bit [7:0] d;
        int n;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        chk(link_rst_n == 0, "R1 link reset low", link_rst_n, 0);
        chk(sync == 0, "R1 sync low", sync, 0);
        chk(irq == 0, "R1 irq low", irq, 0);
        rd(0, d); chk(d == 0, "R1 ctrl", d, 0);
        rd(1, d); chk(d == 0, "R1 status", d, 0);
        rd(2, d); chk(d == 0, "R1 irq enable", d, 0);

        // R6 data high and clock toggling while the link is disabled
        sd_mode[1] = 3; bc_half = 4;
        run_cycles(60);
        bc_half = 0;
        chk(sync == 0, "R3 no sync while disabled", sync, 0);
        sd_mode[1] = 0;
        run_cycles(10);
        rd(1, d); chk(d == 0, "R6 no status while unframed", d, 0);

        // R2 release the link
        wr(0, 8'h01);
        cyc();
        chk(link_rst_n == 1, "R2 release", link_rst_n, 1);
        run_cycles(100);
        chk(sync == 0, "R3 idle clock", sync, 0);

        // R3 slow toggles never accumulate
        for (int k = 0; k < 5; k++) begin
            b_bc = ~b_bc;
            run_cycles(100);
        end
        chk(sync == 0, "R3 slow toggles", sync, 0);
        // R3 three fast toggles then stop
        for (int k = 0; k < 3; k++) begin
            b_bc = ~b_bc;
            run_cycles(4);
        end
        run_cycles(150);
        chk(sync == 0, "R3 three toggles", sync, 0);

        // R4 running clock; lane 1 drives non-ready tag bits
        sd_mode[1] = 2; bc_cnt = 0; bc_half = 4;
        n = 0;
        while (!sync && n < 400) begin cyc(); n++; end
        chk(sync == 1, "R4 sync starts", sync, 1);
        n = 0;
        while (sync && n < 4000) begin cyc(); n++; end
        chk(n == 128, "R4 sync width", n, 128);
        while (!sync && n < 4000) begin cyc(); n++; end
        chk(n == 2048, "R4 frame period", n, 2048);

        // R5 lane 0 ready, interrupt masked
        sd_mode[0] = 1;
        run_cycles(4096);
        rd(1, d); chk(d == 8'h01, "R5 lane0 ready", d, 1);
        chk(d[1] == 0, "R6 lane1 non-ready bits ignored", d[1], 0);
        chk(irq == 0, "R8 masked", irq, 0);
        wr(2, 8'h01);
        cyc();
        chk(irq == 1, "R8 enabled", irq, 1);

        // R7 sticky after lane 0 drops, write 0 no effect, write 1 clears
        sd_mode[0] = 0;
        run_cycles(2100);
        rd(1, d); chk(d == 8'h01, "R7 sticky", d, 1);
        wr(1, 8'h00);
        rd(1, d); chk(d == 8'h01, "R7 write zero keeps", d, 1);
        wr(1, 8'h01);
        rd(1, d); chk(d == 8'h00, "R7 clear", d, 0);
        chk(irq == 0, "R8 cleared", irq, 0);

        // R5 lane 1 ready
        sd_mode[1] = 1;
        run_cycles(4096);
        rd(1, d); chk(d == 8'h02, "R5 lane1 ready", d, 2);
        chk(irq == 0, "R8 lane1 masked", irq, 0);
        wr(2, 8'h02);
        cyc();
        chk(irq == 1, "R8 lane1 enabled", irq, 1);
        sd_mode[1] = 0;

        // R9 reassert link reset with the clock still running
        wr(0, 8'h00);
        cyc();
        cyc();
        chk(link_rst_n == 0, "R9 link reset", link_rst_n, 0);
        chk(sync == 0, "R9 sync stopped", sync, 0);
        rd(1, d); chk(d == 8'h02, "R9 status kept", d, 2);
        run_cycles(50);
        wr(0, 8'h01);
        run_cycles(5);
        chk(sync == 0, "R9 redetect before sync", sync, 0);
        n = 0;
        while (!sync && n < 400) begin cyc(); n++; end
        chk(sync == 1, "R9 framing restarts", sync, 1);
        run_cycles(2100);

        finish_run();
    end

endmodule